// File: doc/BRIEF.md
# Receive Flow-Control Pin Generator with Hysteresis

This block drives the hardware flow-control pins of one UART receive channel. It watches the fill level of a 64-entry receive FIFO and decides when to ask the remote transmitter to pause and when to let it resume. A select input routes the flow-controlled request to either the RTS-style pin or the DTR-style pin. The other pin stays under plain software control. Both pins are active-low.

Two threshold schemes are available. The fixed-table scheme uses the trigger levels 8, 16, 56 and 60. It pauses at the table entry above the programmed one and resumes at the entry below it. The programmable scheme takes any trigger level and surrounds it with a symmetric band whose half-width is set by a 4-bit hysteresis code.

Automatic control only acts once software has asserted the selected pin's own control bit. Every change on the selected pin sets a sticky status bit. That bit can raise an interrupt and is cleared by a modem-status read. Reception is never stopped by the block: it keeps signalling that data may be accepted until the FIFO is actually full.

Top module: `rx_flow_ctrl`

## Requirements
- R1: With `auto_en` low, `rts_n` equals the inverse of `mcr_rts` and `dtr_n` equals the inverse of `mcr_dtr` in the same cycle, whatever the FIFO level.
- R2: With `auto_en` high, `sel_dtr`=0 places the flow control on `rts_n` and leaves `dtr_n` equal to the inverse of `mcr_dtr`. `sel_dtr`=1 places the flow control on `dtr_n` and leaves `rts_n` equal to the inverse of `mcr_rts`.
- R3: Flow control is armed only while `auto_en` is high and the selected pin's software bit is 1. While it is not armed, the selected pin equals the inverse of that bit, and the pause state is cleared at the next clock edge.
- R4: In fixed-table mode (`prog_mode`=0), `trig_idx` 0..3 selects the trigger level 8, 16, 56 or 60. An armed, running channel pauses (selected pin driven high) when the level is at or above the next higher entry. For index 3 that threshold is 64. Reaching the programmed level alone does not pause.
- R5: In fixed-table mode, a paused channel resumes (pin driven low) when the level is at or below the next lower entry. For index 0 that entry is 0.
- R6: In programmable mode (`prog_mode`=1), the hysteresis equals the numeric value of `hyst_code` (0..15). The channel pauses when the level is at or above `prog_trig`+hysteresis, saturated at 64.
- R7: In programmable mode, a paused channel resumes when the level is below `prog_trig`−hysteresis (saturated at 0) or the level is 0. It does not resume while the pause condition of R6 also holds.
- R8: The level is sampled at the clock edge, so a pause or resume shows on the pin right after the edge at which its condition held. Changes of the software bits, `auto_en` and `sel_dtr` reach the pins within the same cycle.
- R9: `rx_accept` is 1 exactly when the level is below 64, independent of the pause state.
- R10: At each clock edge where the selected pin differs from its value at the previous edge, `flow_sts` becomes 1. The remembered value is high after reset.
- R11: A clock edge with `msr_rd` high clears `flow_sts`, unless a pin change is registered at the same edge, in which case `flow_sts` stays 1.
- R12: `flow_irq` is `flow_sts` gated by `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_level | input | 7 | Current receive FIFO fill level, 0..64 |
| auto_en | input | 1 | Automatic flow-control enable |
| sel_dtr | input | 1 | 0: flow control on RTS pin, 1: on DTR pin |
| mcr_rts | input | 1 | Software RTS request bit (1 = asserted) |
| mcr_dtr | input | 1 | Software DTR request bit (1 = asserted) |
| prog_mode | input | 1 | 0: fixed trigger table, 1: programmable trigger |
| trig_idx | input | 2 | Fixed-table trigger index |
| prog_trig | input | 7 | Programmable trigger level |
| hyst_code | input | 4 | Programmable hysteresis half-width |
| irq_en | input | 1 | Pin-change interrupt enable |
| msr_rd | input | 1 | Modem-status read strobe, clears status |
| rts_n | output | 1 | Active-low RTS pin |
| dtr_n | output | 1 | Active-low DTR pin |
| rx_accept | output | 1 | Receive data may still be written to the FIFO |
| flow_sts | output | 1 | Sticky flow-pin change status |
| flow_irq | output | 1 | Flow-pin change interrupt |

## Verification
A stuck or wrong pause state shows up on the selected pin right after the clock edge where the level crossed a threshold. So a threshold that is off by one fails on the very first ramp over that level. A wrong remembered pin value shows up one edge later, as a missing or extra status bit. A clearing rule with the wrong priority shows up only on a read that coincides with a pin change, so that collision is driven on purpose. The reference model recomputes the thresholds and compares every output after every clock, so any divergence is reported in the cycle it appears.

// File: rtl/fc_pkg.sv
package fc_pkg;
  function automatic int sat_add(input int a, input int b, input int lim);
    return (a + b > lim) ? lim : a + b;
  endfunction

  function automatic int sat_sub(input int a, input int b);
    return (a > b) ? a - b : 0;
  endfunction
endpackage

// File: rtl/fc_thresh.sv
module fc_thresh #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7,
  parameter int HYS_W = 4,
  parameter int T0 = 8,
  parameter int T1 = 16,
  parameter int T2 = 56,
  parameter int T3 = 60
) (
  input  logic             prog_mode,
  input  logic [1:0]       trig_idx,
  input  logic [LVL_W-1:0] prog_trig,
  input  logic [HYS_W-1:0] hyst_code,
  output logic [LVL_W-1:0] pause_at,
  output logic [LVL_W-1:0] resume_below
);
  localparam int NTRIG = 4;
  localparam int TBL [NTRIG] = '{T0, T1, T2, T3};

  int tab_up, tab_lo;

  always_comb begin
    tab_up = DEPTH;
    tab_lo = 0;
    for (int i = 0; i < NTRIG; i++) begin
      if (int'(trig_idx) == i) begin
        tab_up = (i == NTRIG - 1) ? DEPTH : TBL[(i + 1) % NTRIG];
        tab_lo = (i == 0) ? 1 : TBL[(i + NTRIG - 1) % NTRIG] + 1;
      end
    end
  end

  always_comb begin
    if (prog_mode) begin
      pause_at     = LVL_W'(fc_pkg::sat_add(int'(prog_trig), int'(hyst_code), DEPTH));
      resume_below = LVL_W'(fc_pkg::sat_sub(int'(prog_trig), int'(hyst_code)));
    end else begin
      pause_at     = LVL_W'(tab_up);
      resume_below = LVL_W'(tab_lo);
    end
  end
endmodule

// File: rtl/fc_pause.sv
module fc_pause #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] pause_at,
  input  logic [LVL_W-1:0] resume_below,
  output logic             paused
);
  logic pause_cond, resume_cond;

  assign pause_cond  = level >= pause_at;
  assign resume_cond = ((level < resume_below) || (level == '0)) && !pause_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    paused <= 1'b0;
    else if (!armed)               paused <= 1'b0;
    else if (!paused && pause_cond) paused <= 1'b1;
    else if (paused && resume_cond) paused <= 1'b0;
  end

  // R3
  disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !paused);
  // R4
  pause_onset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> ($past(level) >= $past(pause_at)));
  // R7
  resume_onset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) |-> (!$past(armed) || $past(level) < $past(resume_below)
                       || $past(level) == '0));
endmodule

// File: rtl/fc_pin_irq.sv
module fc_pin_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic sel_dtr,
  input  logic mcr_rts,
  input  logic mcr_dtr,
  input  logic paused,
  input  logic msr_rd,
  input  logic irq_en,
  output logic rts_n,
  output logic dtr_n,
  output logic flow_sts,
  output logic flow_irq
);
  logic sel_pin, sel_pin_q, pin_evt;

  always_comb begin
    rts_n = ~mcr_rts;
    dtr_n = ~mcr_dtr;
    if (auto_en && !sel_dtr) rts_n = ~(mcr_rts & ~paused);
    if (auto_en &&  sel_dtr) dtr_n = ~(mcr_dtr & ~paused);
  end

  assign sel_pin = sel_dtr ? dtr_n : rts_n;
  assign pin_evt = sel_pin != sel_pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_pin_q <= 1'b1;
      flow_sts  <= 1'b0;
    end else begin
      sel_pin_q <= sel_pin;
      if (pin_evt)     flow_sts <= 1'b1;
      else if (msr_rd) flow_sts <= 1'b0;
    end
  end

  assign flow_irq = flow_sts & irq_en;

  // R10
  change_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pin != sel_pin_q) |=> flow_sts);
  // R11
  read_clears_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && sel_pin == sel_pin_q) |=> !flow_sts);
  // R12
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow_irq |-> (irq_en && flow_sts));
endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl #(
  parameter int DEPTH = 64,
  parameter int HYS_W = 4,
  parameter int T0 = 8,
  parameter int T1 = 16,
  parameter int T2 = 56,
  parameter int T3 = 60,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             auto_en,
  input  logic             sel_dtr,
  input  logic             mcr_rts,
  input  logic             mcr_dtr,
  input  logic             prog_mode,
  input  logic [1:0]       trig_idx,
  input  logic [LVL_W-1:0] prog_trig,
  input  logic [HYS_W-1:0] hyst_code,
  input  logic             irq_en,
  input  logic             msr_rd,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             rx_accept,
  output logic             flow_sts,
  output logic             flow_irq
);
  logic [LVL_W-1:0] pause_at, resume_below;
  logic armed, paused;

  assign armed     = auto_en & (sel_dtr ? mcr_dtr : mcr_rts);
  assign rx_accept = fifo_level < LVL_W'(DEPTH);

  fc_thresh #(.DEPTH(DEPTH), .LVL_W(LVL_W), .HYS_W(HYS_W),
              .T0(T0), .T1(T1), .T2(T2), .T3(T3)) u_thresh (
    .prog_mode(prog_mode), .trig_idx(trig_idx), .prog_trig(prog_trig),
    .hyst_code(hyst_code), .pause_at(pause_at), .resume_below(resume_below));

  fc_pause #(.LVL_W(LVL_W)) u_pause (
    .clk(clk), .rst_n(rst_n), .armed(armed), .level(fifo_level),
    .pause_at(pause_at), .resume_below(resume_below), .paused(paused));

  fc_pin_irq u_pin (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .sel_dtr(sel_dtr),
    .mcr_rts(mcr_rts), .mcr_dtr(mcr_dtr), .paused(paused), .msr_rd(msr_rd),
    .irq_en(irq_en), .rts_n(rts_n), .dtr_n(dtr_n), .flow_sts(flow_sts),
    .flow_irq(flow_irq));

  // R9
  accept_while_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && fifo_level < LVL_W'(DEPTH)) |-> rx_accept);
endmodule

// File: tb/rx_flow_ctrl_bench.sv
module rx_flow_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] fifo_level = '0;
  logic auto_en = 0, sel_dtr = 0, mcr_rts = 0, mcr_dtr = 0, prog_mode = 0;
  logic [1:0] trig_idx = '0;
  logic [6:0] prog_trig = '0;
  logic [3:0] hyst_code = '0;
  logic irq_en = 0, msr_rd = 0;
  logic rts_n, dtr_n, rx_accept, flow_sts, flow_irq;

  int vectors = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  int m_paused = 0, m_prev = 1, m_sts = 0;
  int levels[4] = '{8, 16, 56, 60};

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_flow_ctrl u_rx_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .auto_en(auto_en),
    .sel_dtr(sel_dtr), .mcr_rts(mcr_rts), .mcr_dtr(mcr_dtr),
    .prog_mode(prog_mode), .trig_idx(trig_idx), .prog_trig(prog_trig),
    .hyst_code(hyst_code), .irq_en(irq_en), .msr_rd(msr_rd),
    .rts_n(rts_n), .dtr_n(dtr_n), .rx_accept(rx_accept),
    .flow_sts(flow_sts), .flow_irq(flow_irq));

  function automatic int exp_rts();
    if (auto_en && !sel_dtr) return (mcr_rts && m_paused == 0) ? 0 : 1;
    return mcr_rts ? 0 : 1;
  endfunction

  function automatic int exp_dtr();
    if (auto_en && sel_dtr) return (mcr_dtr && m_paused == 0) ? 0 : 1;
    return mcr_dtr ? 0 : 1;
  endfunction

  task automatic model_edge();
    int lvl, up, lob, pin;
    bit armed, hit_up, hit_lo;
    lvl = int'(fifo_level);
    if (!rst_n) begin
      m_paused = 0; m_prev = 1; m_sts = 0;
      return;
    end
    if (prog_mode) begin
      up  = int'(prog_trig) + int'(hyst_code);
      if (up > 64) up = 64;
      lob = int'(prog_trig) - int'(hyst_code);
      if (lob < 0) lob = 0;
    end else begin
      up  = 64;
      lob = 1;
      foreach (levels[k]) begin
        if (k == int'(trig_idx) + 1) up = levels[k];
        if (k == int'(trig_idx) - 1) lob = levels[k] + 1;
      end
    end
    hit_up = lvl >= up;
    hit_lo = (lvl < lob || lvl == 0) && !hit_up;
    pin = sel_dtr ? exp_dtr() : exp_rts();
    armed = auto_en && (sel_dtr ? mcr_dtr : mcr_rts);
    if (!armed) m_paused = 0;
    else if (m_paused == 0 && hit_up) m_paused = 1;
    else if (m_paused == 1 && hit_lo) m_paused = 0;
    if (pin != m_prev) m_sts = 1;
    else if (msr_rd) m_sts = 0;
    m_prev = pin;
  endtask

  task automatic chk(string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("rts_n", int'(rts_n), exp_rts());
    chk("dtr_n", int'(dtr_n), exp_dtr());
    chk("rx_accept", int'(rx_accept), (int'(fifo_level) < 64) ? 1 : 0);
    chk("flow_sts", int'(flow_sts), m_sts);
    chk("flow_irq", int'(flow_irq), (m_sts == 1 && irq_en) ? 1 : 0);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    #1;
    compare_all();
  endtask

  task automatic ramp(int from, int to);
    int s = (to >= from) ? 1 : -1;
    for (int v = from; v != to + s; v += s) begin
      fifo_level = 7'(v);
      cyc();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    cur_req = "R3";
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    cur_req = "R1";
    mcr_rts = 1; ramp(0, 64);
    mcr_dtr = 1; mcr_rts = 0; #1; compare_all(); cyc();
    msr_rd = 1; cyc(); msr_rd = 0;

    cur_req = "R3";
    auto_en = 1; mcr_rts = 0; mcr_dtr = 0; fifo_level = 7'd40;
    cyc(); cyc();
    mcr_rts = 1; #1; compare_all(); cyc();

    cur_req = "R4";
    trig_idx = 2'd1; ramp(0, 64);
    cur_req = "R5";
    ramp(64, 0);
    cur_req = "R4";
    trig_idx = 2'd3; ramp(50, 64);
    cur_req = "R5";
    ramp(64, 50);
    trig_idx = 2'd0; ramp(20, 0);

    cur_req = "R2";
    sel_dtr = 1; mcr_dtr = 1; mcr_rts = 0; trig_idx = 2'd0;
    ramp(0, 20); ramp(20, 0);
    mcr_rts = 1; cyc(); mcr_rts = 0; cyc();

    cur_req = "R6";
    sel_dtr = 0; mcr_rts = 1; prog_mode = 1; prog_trig = 7'd30; hyst_code = 4'd0;
    ramp(25, 35);
    cur_req = "R7";
    ramp(35, 25);
    cur_req = "R6";
    hyst_code = 4'd5; ramp(20, 40);
    cur_req = "R7";
    ramp(40, 20);
    cur_req = "R6";
    prog_trig = 7'd62; hyst_code = 4'd10; ramp(50, 64);
    cur_req = "R7";
    ramp(64, 45);
    prog_trig = 7'd3; hyst_code = 4'd8; ramp(0, 15); ramp(15, 0);
    prog_trig = 7'd0; hyst_code = 4'd0; ramp(0, 3); ramp(3, 0);

    cur_req = "R8";
    prog_trig = 7'd20; hyst_code = 4'd2; ramp(15, 30);
    mcr_rts = 0; #1; compare_all(); cyc();
    mcr_rts = 1; #1; compare_all(); cyc();
    auto_en = 0; #1; compare_all(); cyc();
    auto_en = 1; cyc();

    cur_req = "R9";
    fifo_level = 7'd63; cyc();
    fifo_level = 7'd64; cyc(); cyc();

    cur_req = "R10";
    fifo_level = 7'd0; cyc(); cyc();
    msr_rd = 1; cyc(); msr_rd = 0; cyc();
    cur_req = "R11";
    fifo_level = 7'd30; cyc();
    msr_rd = 1; cyc(); cyc(); msr_rd = 0; cyc();

    cur_req = "R12";
    irq_en = 1; fifo_level = 7'd0; cyc(); cyc();
    irq_en = 0; #1; compare_all(); cyc();
    irq_en = 1; msr_rd = 1; cyc(); msr_rd = 0; cyc();

    cur_req = "R8";
    for (int n = 0; n < 3000; n++) begin
      fifo_level = 7'($urandom_range(0, 64));
      if ($urandom_range(0, 15) == 0) auto_en = ~auto_en;
      if ($urandom_range(0, 15) == 0) sel_dtr = ~sel_dtr;
      if ($urandom_range(0, 7) == 0) mcr_rts = ~mcr_rts;
      if ($urandom_range(0, 7) == 0) mcr_dtr = ~mcr_dtr;
      if ($urandom_range(0, 31) == 0) prog_mode = ~prog_mode;
      if ($urandom_range(0, 31) == 0) trig_idx = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 31) == 0) prog_trig = 7'($urandom_range(0, 64));
      if ($urandom_range(0, 31) == 0) hyst_code = 4'($urandom_range(0, 15));
      irq_en = 1'($urandom_range(0, 1));
      msr_rd = ($urandom_range(0, 5) == 0);
      cyc();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule